// File: doc/BRIEF.md
# Supervisor Reset Pulse Controller

This block merges the reset causes of a processor supervisor into one stretched system reset. It watches three sources: a supply-good flag from an external voltage comparator, a raw active-low pushbutton, and a one-cycle pulse from a watchdog that has expired. While any source is active the reset is held. Once every source has cleared, the reset is kept for a fixed minimum interval before it is let go. A pushbutton press counts only after it has been stable long enough to pass a debounce filter.

All intervals are whole milliseconds measured with a clock-derived millisecond prescaler. C = CLK_HZ/1000 is the number of clock cycles per millisecond, with a minimum of 1. DEB = DEB_MS*C is the debounce length and HOLD = HOLD_MS*C is the stretch length, both in cycles. The reset appears in two forms. One is an active-high push-pull level. The other is an enable that pulls an open-drain, active-low line to ground. With an external pull-up, that line always reads as the complement of the active-high output.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_hi` and `rst_lo_drive` are both 1. After `por_n` rises with no other source active, they stay 1 for exactly HOLD+1 rising edges and fall after the (HOLD+1)-th edge.
- R2: If `supply_ok` is sampled 0 at a rising edge, `rst_hi` is 1 after that edge, and it stays 1 for every edge at which `supply_ok` is sampled 0.
- R3: Let t be the last edge at which any source is seen active. `rst_hi` stays 1 through edge t+HOLD and is 0 after edge t+HOLD+1. A button press is seen by this stage one edge after it is recognised.
- R4: A `btn_n` low level sampled on fewer than DEB consecutive rising edges never asserts the reset.
- R5: A `btn_n` low level sampled on DEB consecutive edges a..a+DEB-1 is recognised. `rst_hi` is 1 after edge a+DEB+2, stays 1 while the button is held, and is then stretched as in R3.
- R6: A single-cycle `wdt_expire` pulse sampled at an edge makes `rst_hi` 1 after that edge, followed by the full stretch of R3.
- R7: A source that becomes active during the stretch restarts the full HOLD-cycle count from the edge where that source is last seen.
- R8: `rst_lo_drive`, where 1 means the line is pulled low, always equals `rst_hi`, so the pulled-up active-low line is the complement of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sets the millisecond base |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply-good flag from the comparator, synchronous to `clk` |
| btn_n | input | 1 | Raw pushbutton, active low, may be asynchronous |
| wdt_expire | input | 1 | One-cycle pulse when the watchdog has run out |
| rst_hi | output | 1 | Stretched reset, active high |
| rst_lo_drive | output | 1 | Pull-low enable for the open-drain, active-low reset line |

## Verification
The assertions assume that `supply_ok` and `wdt_expire` are already synchronous to `clk`, since only the pushbutton passes through a synchronizer. They also assume that `por_n` is low at power-up, so the counters start cleared. The bench drives every input at the falling edge and keeps the watchdog input to single-cycle pulses. It sweeps button pulse lengths on both sides of the debounce length, supply dips of several lengths, and retriggers at many offsets inside the stretch window.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Number of clock cycles in one millisecond; never below one.
  function automatic int cycles_per_ms(input int clk_hz);
    int c;
    c = clk_hz / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // Span of an interval in clock cycles.
  function automatic int span_cycles(input int ms, input int div);
    return ms * div;
  endfunction

  // Bits needed to hold the values 0..n.
  function automatic int width_for(input int n);
    int w;
    w = 1;
    for (int i = 1; i < 32; i++) begin
      if ((64'd1 << w) <= 64'(n)) w = w + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/supv_ms_timer.sv
// Millisecond interval timer: counts whole milliseconds while clear is low,
// saturates at LIMIT_MS and raises reached. Clear restarts from zero.
module supv_ms_timer #(
  parameter int DIV      = 1000,
  parameter int LIMIT_MS = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clear,
  output logic reached
);
  localparam int MSW = supv_pkg::width_for(LIMIT_MS);
  localparam logic [MSW-1:0] MS_END = MSW'(LIMIT_MS);

  logic [MSW-1:0] ms_q;
  logic           tick;

  generate
    if (DIV > 1) begin : g_pre
      localparam int PW = supv_pkg::width_for(DIV - 1);
      localparam logic [PW-1:0] PRE_END = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                pre_q <= '0;
        else if (clear || reached)  pre_q <= '0;
        else if (pre_q == PRE_END)  pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == PRE_END);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               ms_q <= '0;
    else if (clear)            ms_q <= '0;
    else if (tick && !reached) ms_q <= ms_q + 1'b1;
  end

  assign reached = (ms_q == MS_END);
endmodule

// File: rtl/supv_debounce.sv
// A press is accepted once the synchronized button has been low for
// LIMIT_MS whole milliseconds; it is dropped as soon as the button is high.
module supv_debounce #(
  parameter int DIV      = 1000,
  parameter int LIMIT_MS = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic btn_sync_n,
  output logic btn_held
);
  supv_ms_timer #(.DIV(DIV), .LIMIT_MS(LIMIT_MS)) u_tmr (
    .clk     (clk),
    .arst_n  (arst_n),
    .clear   (btn_sync_n),
    .reached (btn_held)
  );
endmodule

// File: rtl/supv_stretch.sv
// Holds the reset while any source is active and for LIMIT_MS after.
module supv_stretch #(
  parameter int DIV      = 1000,
  parameter int LIMIT_MS = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic src,
  output logic hold_next,
  output logic hold_q
);
  logic span_done;

  supv_ms_timer #(.DIV(DIV), .LIMIT_MS(LIMIT_MS)) u_tmr (
    .clk     (clk),
    .arst_n  (arst_n),
    .clear   (src),
    .reached (span_done)
  );

  assign hold_next = src | ~span_done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) hold_q <= 1'b1;
    else         hold_q <= hold_next;
  end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int CLK_HZ  = 1_000_000,
  parameter int DEB_MS  = 20,
  parameter int HOLD_MS = 250
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic btn_n,
  input  logic wdt_expire,
  output logic rst_hi,
  output logic rst_lo_drive
);
  localparam int DIV = supv_pkg::cycles_per_ms(CLK_HZ);

  // Named internal events, brought out for the checker.
  logic btn_sync_n;
  logic btn_held;
  logic any_src;
  logic hold_next;
  logic hold_q;

  supv_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .d_async (btn_n),
    .d_sync  (btn_sync_n)
  );

  supv_debounce #(.DIV(DIV), .LIMIT_MS(DEB_MS)) u_deb (
    .clk        (clk),
    .arst_n     (por_n),
    .btn_sync_n (btn_sync_n),
    .btn_held   (btn_held)
  );

  assign any_src = ~supply_ok | wdt_expire | btn_held;

  supv_stretch #(.DIV(DIV), .LIMIT_MS(HOLD_MS)) u_str (
    .clk       (clk),
    .arst_n    (por_n),
    .src       (any_src),
    .hold_next (hold_next),
    .hold_q    (hold_q)
  );

  // Separate output flop for the open-drain pull-low enable.
  logic lo_drive_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) lo_drive_q <= 1'b1;
    else        lo_drive_q <= hold_next;
  end

  assign rst_hi       = hold_q;
  assign rst_lo_drive = lo_drive_q;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int DEB_CYC  = 20,
  parameter int HOLD_CYC = 250
) (
  input logic clk,
  input logic por_n,
  input logic supply_ok,
  input logic btn_n,
  input logic wdt_expire,
  input logic any_src,
  input logic btn_held,
  input logic rst_hi,
  input logic rst_lo_drive
);
  // Run of consecutive low button samples, and its two-cycle-old copy.
  int unsigned low_run, low_run_d1, low_run_d2;
  // Cycles since a source was last seen active.
  int unsigned quiet;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_run    <= 0;
      low_run_d1 <= 0;
      low_run_d2 <= 0;
      quiet      <= 0;
    end else begin
      if (btn_n)                                low_run <= 0;
      else if (low_run < DEB_CYC)               low_run <= low_run + 1;
      low_run_d1 <= low_run;
      low_run_d2 <= low_run_d1;
      if (any_src)                              quiet <= 0;
      else if (quiet <= HOLD_CYC)               quiet <= quiet + 1;
    end
  end

  assert_supply_low_R2: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rst_hi);

  assert_release_window_R3: assert property (@(posedge clk) disable iff (!por_n)
    rst_hi == (quiet <= HOLD_CYC));

  assert_short_press_ignored_R4: assert property (@(posedge clk) disable iff (!por_n)
    btn_held |-> (low_run_d2 >= DEB_CYC));

  assert_long_press_seen_R5: assert property (@(posedge clk) disable iff (!por_n)
    (low_run_d2 >= DEB_CYC) |-> btn_held);

  assert_wdt_trigger_R6: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expire |=> rst_hi);

  assert_retrigger_R7: assert property (@(posedge clk) disable iff (!por_n)
    (any_src && !$past(any_src)) |=> rst_hi);

  assert_complement_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_lo_drive == rst_hi);
endmodule

bind supv_reset_ctrl supv_reset_chk #(
  .DEB_CYC  (supv_pkg::span_cycles(DEB_MS,  supv_pkg::cycles_per_ms(CLK_HZ))),
  .HOLD_CYC (supv_pkg::span_cycles(HOLD_MS, supv_pkg::cycles_per_ms(CLK_HZ)))
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .supply_ok    (supply_ok),
  .btn_n        (btn_n),
  .wdt_expire   (wdt_expire),
  .any_src      (any_src),
  .btn_held     (btn_held),
  .rst_hi       (rst_hi),
  .rst_lo_drive (rst_lo_drive)
);

// File: tb/sim_supv_reset_ctrl.sv
module sim_supv_reset_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 4000;
  localparam int DEB_MS  = 3;
  localparam int HOLD_MS = 5;
  localparam int C    = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int DEB  = DEB_MS * C;
  localparam int HOLD = HOLD_MS * C;

  logic clk = 0;
  logic por_n = 0;
  logic supply_ok = 1;
  logic btn_n = 1;
  logic wdt_expire = 0;
  logic rst_hi, rst_lo_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_ctrl #(.CLK_HZ(CLK_HZ), .DEB_MS(DEB_MS), .HOLD_MS(HOLD_MS)) u0 (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .wdt_expire(wdt_expire), .rst_hi(rst_hi), .rst_lo_drive(rst_lo_drive)
  );

  // Reference in run-length form: a press counts when the button run that
  // ended two edges back reached DEB; reset holds while the source-free
  // run is at most HOLD.
  int run0, run1, run2, quiet;
  always @(posedge clk) begin
    if (!por_n) begin
      run0 <= 0; run1 <= 0; run2 <= 0; quiet <= 0;
    end else begin
      run0 <= btn_n ? 0 : run0 + 1;
      run1 <= run0;
      run2 <= run1;
      if (!supply_ok || wdt_expire || (run2 >= DEB)) quiet <= 0;
      else quiet <= quiet + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && !done) begin
      check(rst_hi == (quiet <= HOLD), tag, int'(rst_hi), int'(quiet <= HOLD));
      check(rst_lo_drive == rst_hi, "R8", int'(rst_lo_drive), int'(rst_hi));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: held in reset, then power-on stretch
    repeat (3) @(negedge clk);
    check(rst_hi == 1'b1, "R1", int'(rst_hi), 1);
    check(rst_lo_drive == 1'b1, "R1", int'(rst_lo_drive), 1);
    por_n = 1;
    idle(HOLD + 10);
    check(rst_hi == 1'b0, "R1", int'(rst_hi), 0);

    // R2 R3: supply dips of several lengths
    tag = "R2 R3";
    for (int len = 1; len <= 6; len++) begin
      supply_ok = 0; idle(len); supply_ok = 1;
      idle(HOLD + 6);
    end

    // R4: presses shorter than the debounce length
    tag = "R4";
    for (int len = 1; len < DEB; len++) begin
      btn_n = 0; idle(len); btn_n = 1;
      idle(6);
      check(rst_hi == 1'b0, "R4", int'(rst_hi), 0);
    end

    // R5: presses at and beyond the debounce length
    tag = "R5";
    for (int len = DEB; len <= DEB + 6; len++) begin
      btn_n = 0; idle(len); btn_n = 1;
      idle(HOLD + 8);
    end

    // R6: single watchdog pulses
    tag = "R6";
    for (int k = 0; k < 3; k++) begin
      wdt_expire = 1; idle(1); wdt_expire = 0;
      idle(HOLD + 5);
    end

    // R7: retrigger at many offsets inside the stretch
    tag = "R7";
    for (int off = 1; off <= HOLD + 1; off += 3) begin
      wdt_expire = 1; idle(1); wdt_expire = 0;
      idle(off);
      supply_ok = 0; idle(1); supply_ok = 1;
      idle(HOLD + 5);
    end

    finish_run();
  end
endmodule